// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block models a single-clock static RAM with a flow-through read path. On every rising edge it captures the address, write data, chip selects, burst controls and write controls. A read word then appears on the output in the same cycle, through a combinational array read. No second output register sits in the read path.

A burst opens when either of two address strobes is low. One strobe is meant for a processor and the other for a cache controller. A strobe loads the external address into the burst logic and clears a 2-bit counter. While the counter runs, the upper address bits stay fixed. The counter advances only on cycles with the advance input low, and the low two address bits follow it in one of two orders. With the mode pin low the order is linear. With the mode pin high the order is interleaved.

The data word is 36 bits, made of four 9-bit lanes. A global write stores every lane. Otherwise, the byte-write enable together with per-lane selects stores any subset of the lanes. The write data is held for one cycle and is committed to the array on the next rising edge.

Top module: `sync_burst_sram`

## Requirements
- R1: Every input is sampled only on the rising clock edge. In a read cycle, the word at the current burst address is on `dout`, with `dout_vld` high, in the cycle that directly follows the edge that sampled the read.
- R2: When all three chip selects are low and `ads_proc_n` or `ads_ctrl_n` is low at an edge, `addr` is loaded as the burst start and the burst counter is cleared.
- R3: When the device is selected and both strobes are high, the counter adds one (wrapping modulo 4) if `adv_n` is low and holds otherwise. The address bits above bit 1 never change during a burst.
- R4: With `mode` low, the low two address bits equal (start + count) mod 4. From a start of 1 the sequence is 1, 2, 3, 0.
- R5: With `mode` high, the low two address bits equal start XOR count. From a start of 1 the sequence is 1, 0, 3, 2.
- R6: Lane k is `dout`/`din` bits 9k+8 down to 9k. If `gw_n` is high and `bwe_n` is low, only the lanes k with `bw_n[k]` low are written. If `bwe_n` is high, `bw_n` has no effect and the cycle is a read.
- R7: With `gw_n` low, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R8: Write data sampled with its write controls is committed at the next rising edge. A read of that address in the following cycle returns the merged word.
- R9: A cycle opened by `ads_proc_n` low is always a read. Write controls sampled in that cycle are ignored.
- R10: If any chip select is high at an edge, then in the next cycle `dout` is zero and `dout_vld` is low. Strobes and `adv_n` are ignored, and the burst state is held.
- R11: In a write cycle, `dout_vld` is low and `dout` is zero.
- R12: While `rst_n` is low, the device reads as deselected (`dout` zero, `dout_vld` low) and the burst counter is cleared. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2_n | input | 1 | Chip select 2, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low, read-only burst start |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low, bit k for lane k |
| addr | input | AW | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Flow-through read data, zero when idle |
| dout_vld | output | 1 | High when `dout` carries a read word |

## Verification
On every cycle, the bound checker watches the burst counter: it checks the load on a selected strobe, the hold on an idle or deselected cycle, and the single wrapping step on advance. It also checks that a deselect blanks the next cycle's output, that a processor-strobe cycle always produces a read, and that a global write never does. The array contents cannot be seen by a property: the linear and interleaved address orders, the merge of lanes in a partial write, and the read of a strobe-opened cycle returning old data. Only the bench's write-then-read scenarios show these, comparing each word against known lane patterns.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs0_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    ads_proc_n,
  input  logic                    ads_ctrl_n,
  input  logic                    adv_n,
  input  logic                    mode,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             sel_r;
  logic             mode_r;
  logic [AW-1:0]    base_r;
  logic [1:0]       cnt_r;
  logic [LANES-1:0] wm_r;
  logic [DW-1:0]    wd_r;

  logic             sel_in;
  logic             strobe;
  logic [LANES-1:0] wm_in;
  logic [1:0]       lo;
  logic [AW-1:0]    cur_addr;
  logic             rd_ok;

  assign sel_in = !cs0_n && !cs1_n && !cs2_n;
  assign strobe = !ads_proc_n || !ads_ctrl_n;

  always_comb begin
    if (!sel_in || !ads_proc_n) wm_in = '0;
    else if (!gw_n)             wm_in = '1;
    else if (!bwe_n)            wm_in = ~bw_n;
    else                        wm_in = '0;
  end

  assign lo       = mode_r ? (base_r[1:0] ^ cnt_r) : (base_r[1:0] + cnt_r);
  assign cur_addr = {base_r[AW-1:2], lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_r  <= 1'b0;
      mode_r <= 1'b0;
      base_r <= '0;
      cnt_r  <= '0;
      wm_r   <= '0;
      wd_r   <= '0;
    end else begin
      sel_r  <= sel_in;
      mode_r <= mode;
      wm_r   <= wm_in;
      wd_r   <= din;
      if (sel_in) begin
        if (strobe) begin
          base_r <= addr;
          cnt_r  <= '0;
        end else if (!adv_n) begin
          cnt_r  <= cnt_r + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wm_r[k]) mem[cur_addr][k*LANE_W +: LANE_W] <= wd_r[k*LANE_W +: LANE_W];
    end
  end

  assign rd_ok    = sel_r && (wm_r == '0);
  assign dout_vld = rd_ok;
  assign dout     = rd_ok ? mem[cur_addr] : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs0_n,
  input logic          cs1_n,
  input logic          cs2_n,
  input logic          ads_proc_n,
  input logic          ads_ctrl_n,
  input logic          adv_n,
  input logic          gw_n,
  input logic [1:0]    cnt,
  input logic [DW-1:0] dout,
  input logic          dout_vld
);
  logic on;
  assign on = !cs0_n && !cs1_n && !cs2_n;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (on && (!ads_proc_n || !ads_ctrl_n)) |=> (cnt == 2'd0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ads_proc_n && ads_ctrl_n && !adv_n) |=> (cnt == $past(cnt) + 2'd1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ads_proc_n && ads_ctrl_n && adv_n) |=> $stable(cnt));

  a_r10_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (!dout_vld && dout == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> $stable(cnt));

  a_r9_read: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !ads_proc_n) |=> dout_vld);

  a_r7_gw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ads_proc_n && !gw_n) |=> !dout_vld);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.DW(LANES*LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
  .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .gw_n(gw_n),
  .cnt(cnt_r), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam bit H1 = 1'b1;
  localparam bit L0 = 1'b0;

  localparam logic [35:0] WA = {9'h1A0, 9'h1A1, 9'h1A2, 9'h1A3};
  localparam logic [35:0] WB = {9'h0B0, 9'h0B1, 9'h0B2, 9'h0B3};
  localparam logic [35:0] WC = {9'h0C0, 9'h0C1, 9'h0C2, 9'h0C3};
  localparam logic [35:0] WD = {9'h0D0, 9'h0D1, 9'h0D2, 9'h0D3};
  localparam logic [35:0] WE = {9'h1E0, 9'h1E1, 9'h1E2, 9'h1E3};
  localparam logic [35:0] WF = {9'h0F0, 9'h0F1, 9'h0F2, 9'h0F3};
  localparam logic [35:0] WG = {9'h170, 9'h171, 9'h172, 9'h173};
  localparam logic [35:0] WH = {9'h155, 9'h156, 9'h157, 9'h158};
  localparam logic [35:0] WM = {9'h0B0, 9'h1E1, 9'h0B2, 9'h1E3};
  localparam logic [35:0] WN = {9'h170, 9'h0F1, 9'h0F2, 9'h0F3};
  localparam logic [35:0] Z  = 36'h0;

  typedef struct packed {
    logic [7:0]  req;
    logic        sel, ps, cs, adv, gw, bwe;
    logic [3:0]  bw;
    logic        mode;
    logic [5:0]  addr;
    logic [35:0] din;
    logic        evld;
    logic [35:0] edout;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{8'd7,  H1,L0,H1,L0,H1,L0,4'h0,L0,6'd8,  WA,L0,Z },  // R7, R11 global write
    '{8'd7,  H1,L0,H1,L0,H1,L0,4'h0,L0,6'd9,  WB,L0,Z },
    '{8'd7,  H1,L0,H1,L0,H1,L0,4'h0,L0,6'd10, WC,L0,Z },
    '{8'd11, H1,L0,H1,L0,H1,L0,4'h0,L0,6'd11, WD,L0,Z },  // R11
    '{8'd1,  H1,H1,L0,L0,L0,L0,4'h0,L0,6'd8,  Z, H1,WA},  // R1 flow-through read
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WB},  // R4 linear
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WC},
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WD},
    '{8'd3,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WA},  // R3 wrap
    '{8'd3,  H1,L0,L0,L0,L0,L0,4'h0,L0,6'd0,  Z, H1,WA},  // R3 hold
    '{8'd5,  H1,H1,L0,L0,L0,L0,4'h0,H1,6'd9,  Z, H1,WB},  // R5 interleaved from 1
    '{8'd5,  H1,L0,L0,H1,L0,L0,4'h0,H1,6'd0,  Z, H1,WA},
    '{8'd5,  H1,L0,L0,H1,L0,L0,4'h0,H1,6'd0,  Z, H1,WD},
    '{8'd5,  H1,L0,L0,H1,L0,L0,4'h0,H1,6'd0,  Z, H1,WC},
    '{8'd2,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd9,  Z, H1,WB},  // R2 controller strobe
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WC},
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WD},
    '{8'd4,  H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WA},  // R4 linear 1,2,3,0
    '{8'd10, L0,L0,L0,L0,L0,L0,4'h0,L0,6'd0,  Z, L0,Z },  // R10 deselect
    '{8'd6,  H1,L0,H1,L0,L0,H1,4'h5,L0,6'd9,  WE,L0,Z },  // R6 lanes 0 and 2
    '{8'd8,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd9,  Z, H1,WM},  // R8 merged word
    '{8'd7,  H1,L0,H1,L0,H1,H1,4'h1,L0,6'd10, WF,L0,Z },  // R7 overrides lanes
    '{8'd7,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd10, Z, H1,WF},
    '{8'd6,  H1,L0,H1,L0,L0,L0,4'hF,L0,6'd11, WG,H1,WD},  // R6 no bwe
    '{8'd6,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd11, Z, H1,WD},
    '{8'd9,  H1,H1,L0,L0,H1,L0,4'h0,L0,6'd8,  WH,H1,WA},  // R9 forced read
    '{8'd9,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd8,  Z, H1,WA},
    '{8'd10, L0,H1,L0,L0,L0,L0,4'h0,L0,6'd12, Z, L0,Z },  // R10 strobe ignored
    '{8'd10, H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0,  Z, H1,WM},
    '{8'd6,  H1,L0,H1,L0,L0,H1,4'h8,L0,6'd10, WG,L0,Z },  // R6 lane 3
    '{8'd8,  H1,L0,H1,L0,L0,L0,4'h0,L0,6'd10, Z, H1,WN}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cs0_n, cs1_n, cs2_n, ads_proc_n, ads_ctrl_n, adv_n, mode, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_vld;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .mode(mode),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  task automatic drive(input vec_t v);
    cs0_n      = ~v.sel;
    cs1_n      = ~v.sel;
    cs2_n      = ~v.sel;
    ads_proc_n = ~v.ps;
    ads_ctrl_n = ~v.cs;
    adv_n      = ~v.adv;
    gw_n       = ~v.gw;
    bwe_n      = ~v.bwe;
    bw_n       = ~v.bw;
    mode       = v.mode;
    addr       = v.addr;
    din        = v.din;
  endtask

  task automatic check(input int req, input logic evld, input logic [35:0] edout);
    n_run++;
    if (dout_vld !== evld || dout !== edout) begin
      n_fail++;
      $display("FAIL R%0d: dout_vld=%b dout=%h expected dout_vld=%b dout=%h",
               req, dout_vld, dout, evld, edout);
    end
  endtask

  task automatic cycle(input vec_t v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    check(int'(v.req), v.evld, v.edout);
  endtask

  initial begin
    vec_t idle;
    vec_t v;
    idle = '{8'd12, L0,L0,L0,L0,L0,L0,4'h0,L0,6'd0, Z, L0, Z};
    rst_n = 1'b0;
    drive(idle);
    repeat (2) @(posedge clk);
    #1;
    check(12, 1'b0, Z);  // R12 reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) cycle(TBL[i]);

    // R10: a single inactive select blocks a processor strobe
    @(negedge clk);
    v = '{8'd10, H1,H1,L0,L0,L0,L0,4'h0,L0,6'd8, Z, L0, Z};
    drive(v);
    cs2_n = 1'b1;
    @(posedge clk);
    #1;
    check(10, 1'b0, Z);
    // R10: burst state kept, so advance continues from base 10 to 11
    cycle('{8'd10, H1,L0,L0,H1,L0,L0,4'h0,L0,6'd0, Z, H1, WD});

    // R12: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    drive('{8'd12, H1,L0,H1,L0,L0,L0,4'h0,L0,6'd11, Z, L0, Z});
    @(posedge clk);
    #1;
    check(12, 1'b0, Z);
    @(negedge clk);
    rst_n = 1'b1;
    cycle('{8'd1, H1,L0,H1,L0,L0,L0,4'h0,L0,6'd11, Z, H1, WD});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule